// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control half of a processor-style datapath. It holds a fixed microprogram in an internal read-only store and a control address register that selects the current microword. While the sequencer runs, the control field of the addressed word goes straight to the datapath. In the same cycle, the word's sequencing fields and the status flags decide the next address: the next word in order, a target held in the word, a target taken only when a chosen flag condition holds, an address supplied from outside, or a return to the initial address that stops the sequencer.

There is no pipeline register after the store. A new address is loaded on each rising edge, and the word at that address drives the outputs combinationally until the next edge. The status flags are captured on the same edge that loads the address. A conditional branch therefore tests the flags that the previous microoperation produced. After reset the sequencer waits at address 0 until a start request arrives.

Top module: `useq_top`

## Requirements
- R1: While `rst_ni` is low, the address is 0, the sequencer is idle, `ctrl_o` is 0 and the captured flags are 0. While idle, the address stays 0 and `ctrl_o` stays 0 until `start_i` is seen high at a rising edge.
- R2: If `start_i` is high at a rising edge while the sequencer is idle, the sequencer starts running with the address at 0, so word 0 executes in the following cycle. `start_i` has no effect while the sequencer is running.
- R3: The microword is {target[25:19], source[18:16], condition[15:13], control[12:0]}. For address a, the control field is {a[6:0], ~a[5:0]} and the condition field is a[5:3]. Address 127 uses source 4. Otherwise: a[2:0]=7 uses source 2 with target a+9; a[2:0]=3 uses source 1 with target a+2; a[2:0]=5 with a[6]=1 uses source 3; a[2:0]=1 with a[6]=1 uses source 5 with target ~a. Every other word uses source 0. All targets are taken modulo 128, and unlisted targets are 0.
- R4: Source 0, and the unused sources 5 to 7, load address+1 (modulo 128).
- R5: Source 1 loads the word's target.
- R6: Source 2 loads the target when the selected condition is true, and address+1 otherwise. The condition codes are 0: S=1, 1: S=0, 2: C=1, 3: C=0, 4: Z=1, 5: Z=0, 6: always true, 7: never true.
- R7: The flags {S,C,Z} are captured at every rising edge, whether the sequencer is running or idle. A branch tests the values captured at the previous edge, not the live inputs.
- R8: Source 3 loads `ext_addr_i` as sampled at the edge.
- R9: Source 4 loads address 0 and returns the sequencer to idle.
- R10: While running, `ctrl_o` equals the control field of the word at the current address in the same cycle, and `car_o` always shows the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| ext_addr_i | input | 7 | Externally supplied next address |
| flag_s_i | input | 1 | Sign status from datapath |
| flag_c_i | input | 1 | Carry status from datapath |
| flag_z_i | input | 1 | Zero status from datapath |
| ctrl_o | output | 13 | Control field of the current microword |
| car_o | output | 7 | Current control address |

## Verification
Two things can fall in the same cycle. A branch word may test a flag while the datapath is already presenting a new flag value, and a start request may arrive while the sequencer is busy. The bench drives fresh random flags, start pulses and external addresses in every cycle, so both cases occur often. A reference model that captures flags one edge late, and ignores start while running, predicts the address and control outputs. Any branch that reads the live flag instead of the captured one, or any restart taken mid-program, shows up as an address mismatch in the cycle after the edge.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned SRC_W  = 3;
  localparam int unsigned COND_W = 3;
  localparam int unsigned CTRL_W = 13;
  localparam int unsigned WORD_W = ADDR_W + SRC_W + COND_W + CTRL_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  localparam logic [SRC_W-1:0] SRC_INC  = 3'd0;
  localparam logic [SRC_W-1:0] SRC_JMP  = 3'd1;
  localparam logic [SRC_W-1:0] SRC_BR   = 3'd2;
  localparam logic [SRC_W-1:0] SRC_EXT  = 3'd3;
  localparam logic [SRC_W-1:0] SRC_INIT = 3'd4;
  localparam logic [SRC_W-1:0] SRC_RSV  = 3'd5;

  typedef struct packed {
    logic [ADDR_W-1:0] tgt;
    logic [SRC_W-1:0]  src;
    logic [COND_W-1:0] cond;
    logic [CTRL_W-1:0] ctrl;
  } uword_t;

  // fixed microprogram, computed per address
  function automatic uword_t gen_word(input logic [ADDR_W-1:0] a);
    uword_t w;
    w.ctrl = CTRL_W'({a, ~a[ADDR_W-2:0]});
    w.cond = a[COND_W+2:3];
    w.tgt  = '0;
    w.src  = SRC_INC;
    if (a == ADDR_W'(DEPTH - 1)) begin
      w.src = SRC_INIT;
    end else if (a[2:0] == 3'd7) begin
      w.src = SRC_BR;
      w.tgt = a + ADDR_W'(9);
    end else if (a[2:0] == 3'd3) begin
      w.src = SRC_JMP;
      w.tgt = a + ADDR_W'(2);
    end else if (a[2:0] == 3'd5 && a[ADDR_W-1]) begin
      w.src = SRC_EXT;
    end else if (a[2:0] == 3'd1 && a[ADDR_W-1]) begin
      w.src = SRC_RSV;
      w.tgt = ~a;
    end
    return w;
  endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output uword_t            word_o
);
  uword_t rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign rom[g] = gen_word(ADDR_W'(g));
  end

  assign word_o = rom[addr_i];
endmodule

// File: rtl/useq_cond.sv
module useq_cond
  import useq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_s_i,
  input  logic              flag_c_i,
  input  logic              flag_z_i,
  input  logic [COND_W-1:0] sel_i,
  output logic              hit_o
);
  logic s_q, c_q, z_q;

  // flags from the previous microoperation, captured with the address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q <= 1'b0;
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      s_q <= flag_s_i;
      c_q <= flag_c_i;
      z_q <= flag_z_i;
    end
  end

  always_comb begin
    unique case (sel_i)
      3'd0:    hit_o = s_q;
      3'd1:    hit_o = ~s_q;
      3'd2:    hit_o = c_q;
      3'd3:    hit_o = ~c_q;
      3'd4:    hit_o = z_q;
      3'd5:    hit_o = ~z_q;
      3'd6:    hit_o = 1'b1;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic [ADDR_W-1:0] car_i,
  input  uword_t            word_i,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] ext_i,
  output logic [ADDR_W-1:0] nxt_o,
  output logic              halt_o
);
  logic [ADDR_W-1:0] inc;
  assign inc = car_i + ADDR_W'(1);

  always_comb begin
    halt_o = 1'b0;
    unique case (word_i.src)
      SRC_JMP:  nxt_o = word_i.tgt;
      SRC_BR:   nxt_o = hit_i ? word_i.tgt : inc;
      SRC_EXT:  nxt_o = ext_i;
      SRC_INIT: begin
        nxt_o  = '0;
        halt_o = 1'b1;
      end
      default:  nxt_o = inc;
    endcase
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic              flag_s_i,
  input  logic              flag_c_i,
  input  logic              flag_z_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [ADDR_W-1:0] car_o
);
  logic [ADDR_W-1:0] car_q;
  logic              run_q;
  uword_t            word;
  logic              hit;
  logic [ADDR_W-1:0] nxt;
  logic              halt;

  useq_rom u_rom (
    .addr_i (car_q),
    .word_o (word)
  );

  useq_cond u_cond (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flag_s_i (flag_s_i),
    .flag_c_i (flag_c_i),
    .flag_z_i (flag_z_i),
    .sel_i    (word.cond),
    .hit_o    (hit)
  );

  useq_next u_next (
    .car_i  (car_q),
    .word_i (word),
    .hit_i  (hit),
    .ext_i  (ext_addr_i),
    .nxt_o  (nxt),
    .halt_o (halt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_q <= '0;
      run_q <= 1'b0;
    end else if (!run_q) begin
      car_q <= '0;
      if (start_i) run_q <= 1'b1;
    end else begin
      car_q <= nxt;
      if (halt) run_q <= 1'b0;
    end
  end

  assign ctrl_o = run_q ? word.ctrl : '0;
  assign car_o  = car_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start_i) |=> (!run_q && car_q == '0)); // R1
  AST_START_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && start_i) |=> (run_q && car_q == '0)); // R2
  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && (word.src == SRC_INC || word.src >= SRC_RSV)) |=> (car_q == $past(car_q) + ADDR_W'(1))); // R4
  AST_JMP_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && word.src == SRC_JMP) |=> (car_q == $past(word.tgt))); // R5
  AST_BR_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && word.src == SRC_BR && hit) |=> (car_q == $past(word.tgt))); // R6
  AST_BR_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && word.src == SRC_BR && !hit) |=> (car_q == $past(car_q) + ADDR_W'(1))); // R6
  AST_EXT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && word.src == SRC_EXT) |=> (car_q == $past(ext_addr_i))); // R8
  AST_HALT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && word.src == SRC_INIT) |=> (!run_q && car_q == '0)); // R9
endmodule

// File: tb/sim_useq_top.sv
`timescale 1ns/1ps
module sim_useq_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       start_i;
  logic [6:0] ext_addr_i;
  logic       flag_s_i, flag_c_i, flag_z_i;
  logic [12:0] ctrl_o;
  logic [6:0]  car_o;

  int total = 0;
  int bad = 0;
  logic [31:0] rnd = 32'h1234_5678;

  logic       m_run;
  logic [6:0] m_car;
  logic [2:0] m_flg;
  string      m_tag;

  always #2 clk_i = ~clk_i;

  useq_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ext_addr_i(ext_addr_i),
    .flag_s_i(flag_s_i), .flag_c_i(flag_c_i), .flag_z_i(flag_z_i),
    .ctrl_o(ctrl_o), .car_o(car_o)
  );

  function automatic logic [31:0] nrand(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  // microprogram per R3: returns {tgt, src, cond}
  function automatic logic [12:0] spec_word(input int a);
    int tg = 0, sr = 0;
    if (a == 127) sr = 4;
    else if (a % 8 == 7) begin sr = 2; tg = (a + 9) % 128; end
    else if (a % 8 == 3) begin sr = 1; tg = (a + 2) % 128; end
    else if (a % 8 == 5 && a >= 64) sr = 3;
    else if (a % 8 == 1 && a >= 64) begin sr = 5; tg = 127 - a; end
    return {tg[6:0], sr[2:0], 3'((a / 8) % 8)};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_run = 1'b0; m_car = '0; m_flg = '0; m_tag = "R1";
  endtask

  // one rising edge of the reference model
  task automatic model_edge();
    logic [12:0] w;
    logic [2:0] sr, cd;
    logic       hit;
    if (!rst_ni) begin model_reset(); return; end
    if (!m_run) begin
      if (start_i) begin m_run = 1'b1; m_tag = "R2"; end else m_tag = "R1";
      m_car = '0;
    end else begin
      w = spec_word(int'(m_car));
      sr = w[5:3]; cd = w[2:0];
      case (cd)
        3'd0: hit = m_flg[2];
        3'd1: hit = !m_flg[2];
        3'd2: hit = m_flg[1];
        3'd3: hit = !m_flg[1];
        3'd4: hit = m_flg[0];
        3'd5: hit = !m_flg[0];
        3'd6: hit = 1'b1;
        default: hit = 1'b0;
      endcase
      case (sr)
        3'd1: begin m_car = w[12:6]; m_tag = "R5"; end
        3'd2: begin m_car = hit ? w[12:6] : m_car + 7'd1; m_tag = "R6_R7"; end
        3'd3: begin m_car = ext_addr_i; m_tag = "R8"; end
        3'd4: begin m_car = '0; m_run = 1'b0; m_tag = "R9"; end
        default: begin m_car = m_car + 7'd1; m_tag = "R4"; end
      endcase
    end
    m_flg = {flag_s_i, flag_c_i, flag_z_i};
  endtask

  task automatic check_out();
    logic [12:0] ec;
    ec = m_run ? {m_car, ~m_car[5:0]} : 13'd0;
    chk(car_o == m_car, m_tag, int'(car_o), int'(m_car));
    chk(ctrl_o == ec, m_run ? "R10_R3" : "R1", int'(ctrl_o), int'(ec));
  endtask

  task automatic rand_inputs(input int start_pct);
    rnd = nrand(rnd);
    {flag_s_i, flag_c_i, flag_z_i} = rnd[2:0];
    ext_addr_i = rnd[9:3];
    start_i = (int'(rnd[16:10]) % 100) < start_pct;
  endtask

  task automatic cycle();
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check_out();
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; ext_addr_i = '0;
    flag_s_i = 1'b0; flag_c_i = 1'b0; flag_z_i = 1'b0;
    model_reset();
    repeat (3) begin @(negedge clk_i); check_out(); end  // R1 in reset
    rst_ni = 1'b1;
    // R1: idle hold with active flags and ext
    for (int i = 0; i < 12; i++) begin rand_inputs(0); cycle(); end
    // R2: start
    rand_inputs(0); start_i = 1'b1; cycle();
    for (int i = 0; i < 40000; i++) begin
      rand_inputs(6);
      if (rnd[31:22] == 10'd5) begin
        rst_ni = 1'b0; model_reset();
        #0.5 check_out();
        repeat (2) cycle();
        rst_ni = 1'b1;
      end else begin
        cycle();
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule